// File: doc/BRIEF.md
# Private Interrupt Pending and Trigger Tracker

This block keeps the pending and active state of the sixteen private peripheral interrupts of a single CPU interface, IDs 16 to 31. It also holds this CPU's own copy of the two trigger-configuration words that cover IDs 0 to 31. Each interrupt owns a 2-bit field in those words. The upper bit picks edge-triggered (1) or level-sensitive (0). The lower bit is a distribution-model flag: it is stored and read back, but it changes no behaviour.

The trigger type decides how pending is set and cleared. An edge source becomes pending on a rising edge of its line. It stays pending until software clears it or the CPU acknowledges it. A level source is pending on every cycle its line is high and drops out as soon as the line goes low. An acknowledge leaves a level source pending. The first configuration word describes the software-generated IDs 0 to 15. It is fixed: writes to it are dropped and it always reads zero. An acknowledge makes the interrupt active, and an end-of-interrupt strobe clears the active bit again.

Top module: `ppi_pend_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the pending vector, the active vector and both config words read zero.
- R2: A write to config word index 1 stores all 32 bits, and the value reads back on `cfg_rd_data` in the next cycle. ID 16+i uses bits [2i+1:2i]; bit 2i+1 = 1 means edge-triggered.
- R3: Config word index 0 ignores writes and always reads back zero.
- R4: For an edge-configured ID, a rising edge of its line sets pending in the next cycle. A line that is simply held high does not set pending again once it has been cleared.
- R5: For a level-configured ID, a high line makes the pending bit 1 in the next cycle, on every cycle the line is high.
- R6: For a level-configured ID, a low line makes the pending bit 0 in the next cycle.
- R7: For an edge-configured ID, a falling or low line leaves the pending bit unchanged.
- R8: An acknowledge of ID n (16..31) sets active bit n-16. It also clears pending bit n-16, but only if that ID is edge-configured.
- R9: A clear-pending write clears every pending bit whose mask bit is 1. If a set of the same bit arrives in the same cycle, the set wins.
- R10: An end-of-interrupt for ID n (16..31) clears active bit n-16. An acknowledge of the same ID in the same cycle wins.
- R11: An acknowledge or end-of-interrupt that carries an ID below 16 changes neither vector.
- R12: The lower bit of a config field (the distribution-model flag) has no effect on pending behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Config word write strobe |
| cfg_wr_idx | input | 1 | Config word index being written |
| cfg_wr_data | input | 32 | Config write data |
| cfg_rd_idx | input | 1 | Config word index to read |
| cfg_rd_data | output | 32 | Config readback (combinational) |
| clr_pend_en | input | 1 | Clear-pending write strobe |
| clr_pend_mask | input | 16 | Write-1-to-clear mask, bit i = ID 16+i |
| irq_lines | input | 16 | Peripheral interrupt lines, bit i = ID 16+i |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 5 | Acknowledged interrupt ID |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 5 | Completed interrupt ID |
| pend_vec | output | 16 | Pending bits, bit i = ID 16+i |
| act_vec | output | 16 | Active bits, bit i = ID 16+i |

## Verification
The bench targets the places where the trigger type changes the result:
- An acknowledge of a level source. A design that cleared pending unconditionally would drop it while the line is still high.
- A falling edge line. A design that cleared on every low line would lose an edge interrupt that was never serviced.
- A clear-pending write made while a level line is still high, and an acknowledge and end-of-interrupt of the same ID in the same cycle. A design with the wrong precedence would lose a live interrupt or an active bit.
- A write to config word 0, and a level source that has the distribution-model flag set. A design that stored word 0, or decoded the wrong bit of the field, would turn such sources into edge sources.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int PPI_COUNT      = 16;
    localparam int PPI_FIRST_ID   = 16;
    localparam int CFG_FIELD_W    = 2;
    localparam int CFG_WORD_W     = 32;
    localparam int EDGE_FIELD_BIT = 1;
    localparam int ID_W           = $clog2(PPI_FIRST_ID + PPI_COUNT);
    localparam int CFG_WORDS      = (PPI_FIRST_ID + PPI_COUNT) * CFG_FIELD_W / CFG_WORD_W;
    localparam int CFG_IDX_W      = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;
    localparam int PPI_IDX_W      = $clog2(PPI_COUNT);

    typedef logic [PPI_COUNT-1:0] ppi_vec_t;

    typedef struct packed {
        ppi_vec_t pend;
        ppi_vec_t act;
    } ppi_state_t;
endpackage

// File: rtl/ppi_cfg_bank.sv
module ppi_cfg_bank
    import ppi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CFG_IDX_W-1:0]  wr_idx,
    input  logic [CFG_WORD_W-1:0] wr_data,
    input  logic [CFG_IDX_W-1:0]  rd_idx,
    output logic [CFG_WORD_W-1:0] rd_data,
    output ppi_vec_t              edge_cfg
);
    localparam int FLAT_W = CFG_WORDS * CFG_WORD_W;

    // Word 0 covers the fixed software-generated IDs: never written, stays zero.
    logic [FLAT_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int w = 1; w < CFG_WORDS; w++) begin
            if (wr_en && (wr_idx == CFG_IDX_W'(w))) begin
                cfg_d[w*CFG_WORD_W +: CFG_WORD_W] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign rd_data = cfg_q[rd_idx*CFG_WORD_W +: CFG_WORD_W];

    for (genvar i = 0; i < PPI_COUNT; i++) begin : g_edge
        assign edge_cfg[i] = cfg_q[(PPI_FIRST_ID + i)*CFG_FIELD_W + EDGE_FIELD_BIT];
    end
endmodule

// File: rtl/ppi_line_sampler.sv
module ppi_line_sampler
    import ppi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ppi_vec_t lines,
    output ppi_vec_t rise
);
    ppi_vec_t line_d, line_q;

    always_comb begin
        line_d = lines;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign rise = lines & ~line_q;
endmodule

// File: rtl/ppi_state_update.sv
module ppi_state_update
    import ppi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  ppi_vec_t        edge_cfg,
    input  ppi_vec_t        lines,
    input  ppi_vec_t        rise,
    input  logic            clr_en,
    input  ppi_vec_t        clr_mask,
    input  logic            ack_valid,
    input  logic [ID_W-1:0] ack_id,
    input  logic            eoi_valid,
    input  logic [ID_W-1:0] eoi_id,
    output ppi_state_t      state
);
    ppi_vec_t   ack_sel, eoi_sel;
    ppi_state_t st_d, st_q;

    for (genvar i = 0; i < PPI_COUNT; i++) begin : g_dec
        assign ack_sel[i] = ack_valid && (ack_id == ID_W'(PPI_FIRST_ID + i));
        assign eoi_sel[i] = eoi_valid && (eoi_id == ID_W'(PPI_FIRST_ID + i));
    end

    ppi_vec_t set_v, clr_v;

    always_comb begin
        set_v = (edge_cfg & rise) | (~edge_cfg & lines);
        clr_v = (clr_en ? clr_mask : '0)
              | (ack_sel & edge_cfg)
              | (~edge_cfg & ~lines);
        st_d.pend = set_v | (st_q.pend & ~clr_v);
        st_d.act  = ack_sel | (st_q.act & ~eoi_sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/ppi_pend_ctrl.sv
module ppi_pend_ctrl
    import ppi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [CFG_IDX_W-1:0]  cfg_wr_idx,
    input  logic [CFG_WORD_W-1:0] cfg_wr_data,
    input  logic [CFG_IDX_W-1:0]  cfg_rd_idx,
    output logic [CFG_WORD_W-1:0] cfg_rd_data,
    input  logic                  clr_pend_en,
    input  logic [PPI_COUNT-1:0]  clr_pend_mask,
    input  logic [PPI_COUNT-1:0]  irq_lines,
    input  logic                  ack_valid,
    input  logic [ID_W-1:0]       ack_id,
    input  logic                  eoi_valid,
    input  logic [ID_W-1:0]       eoi_id,
    output logic [PPI_COUNT-1:0]  pend_vec,
    output logic [PPI_COUNT-1:0]  act_vec
);
    ppi_vec_t   edge_cfg;
    ppi_vec_t   line_rise;
    ppi_state_t cur_state;

    ppi_cfg_bank u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_idx   (cfg_wr_idx),
        .wr_data  (cfg_wr_data),
        .rd_idx   (cfg_rd_idx),
        .rd_data  (cfg_rd_data),
        .edge_cfg (edge_cfg)
    );

    ppi_line_sampler u_lines (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_lines),
        .rise  (line_rise)
    );

    ppi_state_update u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_cfg  (edge_cfg),
        .lines     (irq_lines),
        .rise      (line_rise),
        .clr_en    (clr_pend_en),
        .clr_mask  (clr_pend_mask),
        .ack_valid (ack_valid),
        .ack_id    (ack_id),
        .eoi_valid (eoi_valid),
        .eoi_id    (eoi_id),
        .state     (cur_state)
    );

    assign pend_vec = cur_state.pend;
    assign act_vec  = cur_state.act;
endmodule

// File: rtl/ppi_pend_chk.sv
module ppi_pend_chk
    import ppi_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [CFG_IDX_W-1:0]  cfg_rd_idx,
    input logic [CFG_WORD_W-1:0] cfg_rd_data,
    input logic                  clr_pend_en,
    input logic [PPI_COUNT-1:0]  clr_pend_mask,
    input logic [PPI_COUNT-1:0]  irq_lines,
    input logic                  ack_valid,
    input logic [ID_W-1:0]       ack_id,
    input logic                  eoi_valid,
    input logic [ID_W-1:0]       eoi_id,
    input logic [PPI_COUNT-1:0]  pend_vec,
    input logic [PPI_COUNT-1:0]  act_vec,
    input logic [PPI_COUNT-1:0]  edge_cfg,
    input logic [PPI_COUNT-1:0]  line_rise
);
    logic                 ack_hit, eoi_hit;
    logic [ID_W-1:0]      ack_off, eoi_off;
    logic [PPI_IDX_W-1:0] ack_idx, eoi_idx;
    logic [PPI_COUNT-1:0] ack_m, clr_m, lvl_hi, lvl_lo, edge_keep;

    assign ack_hit = ack_valid && (int'(ack_id) >= PPI_FIRST_ID) && (int'(ack_id) < PPI_FIRST_ID + PPI_COUNT);
    assign eoi_hit = eoi_valid && (int'(eoi_id) >= PPI_FIRST_ID) && (int'(eoi_id) < PPI_FIRST_ID + PPI_COUNT);
    assign ack_off = ack_id - ID_W'(PPI_FIRST_ID);
    assign eoi_off = eoi_id - ID_W'(PPI_FIRST_ID);
    assign ack_idx = ack_off[PPI_IDX_W-1:0];
    assign eoi_idx = eoi_off[PPI_IDX_W-1:0];
    assign ack_m   = ack_hit ? (PPI_COUNT'(1) << ack_idx) : '0;
    assign clr_m   = clr_pend_en ? clr_pend_mask : '0;
    assign lvl_hi  = ~edge_cfg & irq_lines;
    assign lvl_lo  = ~edge_cfg & ~irq_lines;
    assign edge_keep = pend_vec & edge_cfg & ~clr_m & ~ack_m;

    AST_CFG0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_idx == '0) |-> (cfg_rd_data == '0)); // R3

    AST_LVL_HIGH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_vec & $past(lvl_hi)) == $past(lvl_hi))); // R5

    AST_LVL_LOW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_vec & $past(lvl_lo)) == '0)); // R6

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_vec & $past(edge_keep)) == $past(edge_keep))); // R7

    AST_ACK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> act_vec[$past(ack_idx)]); // R8

    AST_ACK_EDGE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && edge_cfg[ack_idx] && !line_rise[ack_idx]) |=> !pend_vec[$past(ack_idx)]); // R8

    AST_EOI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && !(ack_hit && ack_idx == eoi_idx)) |=> !act_vec[$past(eoi_idx)]); // R10

    AST_LOW_ID_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_hit && !eoi_hit) |=> $stable(act_vec)); // R11
endmodule

bind ppi_pend_ctrl ppi_pend_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_rd_idx    (cfg_rd_idx),
    .cfg_rd_data   (cfg_rd_data),
    .clr_pend_en   (clr_pend_en),
    .clr_pend_mask (clr_pend_mask),
    .irq_lines     (irq_lines),
    .ack_valid     (ack_valid),
    .ack_id        (ack_id),
    .eoi_valid     (eoi_valid),
    .eoi_id        (eoi_id),
    .pend_vec      (pend_vec),
    .act_vec       (act_vec),
    .edge_cfg      (edge_cfg),
    .line_rise     (line_rise)
);

// File: tb/ppi_pend_ctrl_tb.sv
module ppi_pend_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [0:0]  cfg_wr_idx;
    logic [31:0] cfg_wr_data;
    logic [0:0]  cfg_rd_idx;
    logic [31:0] cfg_rd_data;
    logic        clr_pend_en;
    logic [15:0] clr_pend_mask;
    logic [15:0] irq_lines;
    logic        ack_valid;
    logic [4:0]  ack_id;
    logic        eoi_valid;
    logic [4:0]  eoi_id;
    logic [15:0] pend_vec;
    logic [15:0] act_vec;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ppi_pend_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
        .clr_pend_en(clr_pend_en), .clr_pend_mask(clr_pend_mask),
        .irq_lines(irq_lines),
        .ack_valid(ack_valid), .ack_id(ack_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id),
        .pend_vec(pend_vec), .act_vec(act_vec)
    );

    typedef struct packed {
        logic [15:0] lines;
        logic        clr_en;
        logic [15:0] clr;
        logic        ack_v;
        logic [4:0]  ack_i;
        logic        eoi_v;
        logic [4:0]  eoi_i;
        logic [15:0] exp_pend;
        logic [15:0] exp_act;
    } vec_t;

    // Config used: IDs 16..23 edge, IDs 24..31 level, ID 24 has the model flag set.
    localparam logic [31:0] CFG_WORD1 = 32'h0001_AAAA;

    localparam vec_t VECS [12] = '{
        '{16'h0101, 1'b0, 16'h0000, 1'b0, 5'd0,  1'b0, 5'd0,  16'h0101, 16'h0000}, // R4 R5 rise / level high
        '{16'h0101, 1'b0, 16'h0000, 1'b0, 5'd0,  1'b0, 5'd0,  16'h0101, 16'h0000}, // R4 R5 held high
        '{16'h0000, 1'b0, 16'h0000, 1'b0, 5'd0,  1'b0, 5'd0,  16'h0001, 16'h0000}, // R6 R7 R12 lines drop
        '{16'h0000, 1'b0, 16'h0000, 1'b1, 5'd16, 1'b0, 5'd0,  16'h0000, 16'h0001}, // R8 ack edge source
        '{16'h0100, 1'b0, 16'h0000, 1'b1, 5'd24, 1'b0, 5'd0,  16'h0100, 16'h0101}, // R8 ack level source keeps pending
        '{16'h0100, 1'b1, 16'h0100, 1'b0, 5'd0,  1'b0, 5'd0,  16'h0100, 16'h0101}, // R9 set wins over clear
        '{16'h0002, 1'b0, 16'h0000, 1'b0, 5'd0,  1'b0, 5'd0,  16'h0002, 16'h0101}, // R4 R6 new edge, level low
        '{16'h0002, 1'b1, 16'h0002, 1'b0, 5'd0,  1'b0, 5'd0,  16'h0000, 16'h0101}, // R9 R4 clear, no re-set while held
        '{16'h0000, 1'b0, 16'h0000, 1'b0, 5'd0,  1'b1, 5'd16, 16'h0000, 16'h0100}, // R10 eoi
        '{16'h0000, 1'b0, 16'h0000, 1'b1, 5'd5,  1'b1, 5'd8,  16'h0000, 16'h0100}, // R11 low IDs ignored
        '{16'h0000, 1'b0, 16'h0000, 1'b1, 5'd17, 1'b1, 5'd17, 16'h0000, 16'h0102}, // R10 ack wins over eoi
        '{16'h0000, 1'b0, 16'h0000, 1'b0, 5'd0,  1'b1, 5'd24, 16'h0000, 16'h0002}  // R10 eoi level ID
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        cfg_wr_en = 1'b0; cfg_wr_idx = '0; cfg_wr_data = '0;
        clr_pend_en = 1'b0; clr_pend_mask = '0;
        irq_lines = '0; ack_valid = 1'b0; ack_id = '0;
        eoi_valid = 1'b0; eoi_id = '0;
    endtask

    initial begin
        idle_inputs();
        cfg_rd_idx = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 pend in reset", {16'h0, pend_vec}, 32'h0);
        check("R1 act in reset", {16'h0, act_vec}, 32'h0);
        check("R1 cfg word1 in reset", cfg_rd_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: configure word 1
        cfg_wr_en = 1'b1; cfg_wr_idx = 1'b1; cfg_wr_data = CFG_WORD1;
        @(posedge clk); #1;
        check("R2 cfg word1 readback", cfg_rd_data, CFG_WORD1);
        @(negedge clk);
        // R3: word 0 write dropped
        cfg_wr_idx = 1'b0; cfg_wr_data = 32'hFFFF_FFFF; cfg_rd_idx = 1'b0;
        @(posedge clk); #1;
        check("R3 cfg word0 reads zero", cfg_rd_data, 32'h0);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_rd_idx = 1'b1;
        @(posedge clk); #1;
        check("R3 word1 untouched by word0 write", cfg_rd_data, CFG_WORD1);
        check("R1 pend idle after config", {16'h0, pend_vec}, 32'h0);

        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            irq_lines     = VECS[k].lines;
            clr_pend_en   = VECS[k].clr_en;
            clr_pend_mask = VECS[k].clr;
            ack_valid     = VECS[k].ack_v;
            ack_id        = VECS[k].ack_i;
            eoi_valid     = VECS[k].eoi_v;
            eoi_id        = VECS[k].eoi_i;
            @(posedge clk); #1;
            check($sformatf("table vec %0d pending", k), {16'h0, pend_vec}, {16'h0, VECS[k].exp_pend});
            check($sformatf("table vec %0d active", k), {16'h0, act_vec}, {16'h0, VECS[k].exp_act});
        end

        // R12 directed: ID 24 (model flag set) behaves as level, clears on low line
        @(negedge clk);
        idle_inputs();
        irq_lines = 16'h0100;
        @(posedge clk); #1;
        check("R12 flagged level ID sets", {16'h0, pend_vec}, 32'h0000_0100);
        @(negedge clk);
        irq_lines = 16'h0000;
        @(posedge clk); #1;
        check("R12 flagged level ID clears on low", {16'h0, pend_vec}, 32'h0);

        // R1: reset again clears state and config
        @(negedge clk);
        irq_lines = 16'h0001;
        @(posedge clk); #1;
        check("R4 edge set before reset", {16'h0, pend_vec}, 32'h0000_0001);
        @(negedge clk);
        rst_n = 1'b0;
        irq_lines = 16'h0000;
        @(posedge clk); #1;
        check("R1 pend cleared by reset", {16'h0, pend_vec}, 32'h0);
        check("R1 act cleared by reset", {16'h0, act_vec}, 32'h0);
        check("R1 cfg cleared by reset", cfg_rd_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule